// File: doc/BRIEF.md
# Reset-Sampled Strap Configuration Latch

This block reads a small set of active-low strap pins once per reset and turns them into steady, active-high configuration bits for the rest of the chip. The straps select four options: output high-impedance mode, a built-in self-test run, ignoring machine-check error signalling, and ignoring bus-initialisation signalling. They also carry a two-bit symmetric arbitration agent number. The logic that consumes these bits sits outside the block.

Each strap pin passes through a two-stage synchronizer. The capture happens on the first clock edge at which the block sees the reset input high. At that edge the synchronized pin values are inverted and stored. They then stay fixed until the next reset, and a `cfg_valid` flag marks when they can be used. A warm reset and a cold reset are handled the same way: the power-good input never affects what is captured or when.

Top module: `strap_capture`

## Requirements
- R1: The capture happens at the first rising clock edge after `rst_n` goes high. `cfg_valid` rises at that same edge and is low in the clock cycle where `rst_n` has gone high but that edge has not yet occurred.
- R2: While `rst_n` is low, every `cfg_*` output, including `cfg_valid`, reads 0.
- R3: After the capture, changes on any strap pin leave every `cfg_*` output unchanged until `rst_n` goes low again.
- R4: `strap_hiz_n` low at release gives `cfg_hiz` = 1, and high gives 0. `strap_selftest_n` low at release gives `cfg_selftest` = 1, and high gives 0.
- R5: `strap_mchk_n` low at release gives `cfg_mchk_ignore` = 1. `strap_busi_n` low at release gives `cfg_busi_ignore` = 1. A high pin gives 0 in each case.
- R6: `cfg_agent_id` is the bitwise inverse of `strap_agent_n` at release, so pins 2'b11 give ID 0 and pins 2'b00 give ID 3.
- R7: Every reset pulse causes a fresh capture. The result is the same whether `pwr_ok` stayed high (warm reset) or was low (cold reset). Toggling `pwr_ok` after the capture changes no output.
- R8: The value captured is the one the straps held during the last two or more clock cycles before release. An earlier value held during the same reset is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; its release triggers the capture |
| pwr_ok | input | 1 | Power-good flag; has no effect on the capture |
| strap_hiz_n | input | 1 | Active-low strap requesting output high-impedance mode |
| strap_selftest_n | input | 1 | Active-low strap requesting built-in self-test |
| strap_mchk_n | input | 1 | Active-low strap disabling machine-check error observation |
| strap_busi_n | input | 1 | Active-low strap disabling bus-init observation |
| strap_agent_n | input | ARB_W | Active-low arbitration agent number |
| cfg_hiz | output | 1 | Output high-impedance mode selected |
| cfg_selftest | output | 1 | Self-test selected |
| cfg_mchk_ignore | output | 1 | Machine-check observation disabled |
| cfg_busi_ignore | output | 1 | Bus-init observation disabled |
| cfg_agent_id | output | ARB_W | Arbitration agent number |
| cfg_valid | output | 1 | Configuration has been captured since the last reset |

## Verification
The hardest case to reach is a strap value that changes inside the same reset pulse just before release. The latch has to discard the earlier value and take the later one, and it has to do so across the synchronizer delay. The bench reaches this case by holding one pattern for several cycles with reset low, then switching to a second pattern a few cycles before it releases reset. A second hard case is a warm reset that arrives while a configuration is already live. The bench releases reset, moves the straps, and pulses reset with `pwr_ok` held high, then checks that the new pattern replaces the old one.

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int ARB_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_ok,
  input  logic             strap_hiz_n,
  input  logic             strap_selftest_n,
  input  logic             strap_mchk_n,
  input  logic             strap_busi_n,
  input  logic [ARB_W-1:0] strap_agent_n,
  output logic             cfg_hiz,
  output logic             cfg_selftest,
  output logic             cfg_mchk_ignore,
  output logic             cfg_busi_ignore,
  output logic [ARB_W-1:0] cfg_agent_id,
  output logic             cfg_valid
);
  localparam int W = 4 + ARB_W;

  logic [W-1:0] raw;
  logic [W-1:0] sync_q [SYNC_STAGES];
  logic [W-1:0] strap_s;
  logic [W-1:0] cfg_q;
  logic         rst_seen;
  logic         release_pulse;

  assign raw = {strap_agent_n, strap_busi_n, strap_mchk_n, strap_selftest_n, strap_hiz_n};

  // Synchronizer runs without reset so the straps settle while rst_n is low.
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) sync_q[g] <= raw;
      end else begin : g_next
        always_ff @(posedge clk) sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  assign strap_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_seen <= 1'b0;
    else        rst_seen <= 1'b1;
  end

  assign release_pulse = rst_n && !rst_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cfg_q <= '0;
    else if (release_pulse) cfg_q <= ~strap_s;
  end

  assign cfg_hiz         = cfg_q[0];
  assign cfg_selftest    = cfg_q[1];
  assign cfg_mchk_ignore = cfg_q[2];
  assign cfg_busi_ignore = cfg_q[3];
  assign cfg_agent_id    = cfg_q[W-1:4];
  assign cfg_valid       = rst_seen;

  always @(posedge clk)
    if (!rst_n) AST_RESET_DEFAULTS: assert (cfg_q == '0 && !cfg_valid); // R2

  AST_VALID_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_valid) |-> $past(release_pulse)); // R1
  AST_HOLD_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> $stable(cfg_q)); // R3
  AST_HIZ_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    release_pulse |=> cfg_hiz == !$past(strap_s[0]) && cfg_selftest == !$past(strap_s[1])); // R4
  AST_OBS_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    release_pulse |=> cfg_mchk_ignore == !$past(strap_s[2]) && cfg_busi_ignore == !$past(strap_s[3])); // R5
  AST_AGENT_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
    release_pulse |=> cfg_agent_id == ~$past(strap_s[W-1:4])); // R6
  AST_PWR_OK_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !$stable(pwr_ok) |-> $stable(cfg_q)); // R7
endmodule

// File: tb/test_strap_capture.sv
module test_strap_capture;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_ok = 1'b0;
  logic       hiz_n = 1'b1, st_n = 1'b1, mc_n = 1'b1, bi_n = 1'b1;
  logic [1:0] ag_n = 2'b11;
  logic       cfg_hiz, cfg_selftest, cfg_mchk_ignore, cfg_busi_ignore, cfg_valid;
  logic [1:0] cfg_agent_id;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  strap_capture i_strap_capture (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok),
    .strap_hiz_n(hiz_n), .strap_selftest_n(st_n), .strap_mchk_n(mc_n),
    .strap_busi_n(bi_n), .strap_agent_n(ag_n),
    .cfg_hiz(cfg_hiz), .cfg_selftest(cfg_selftest), .cfg_mchk_ignore(cfg_mchk_ignore),
    .cfg_busi_ignore(cfg_busi_ignore), .cfg_agent_id(cfg_agent_id), .cfg_valid(cfg_valid));

  // packed view: {valid, agent[1:0], busi, mchk, selftest, hiz}
  function automatic logic [6:0] outs();
    return {cfg_valid, cfg_agent_id, cfg_busi_ignore, cfg_mchk_ignore, cfg_selftest, cfg_hiz};
  endfunction

  task automatic chk(input string req, input logic [6:0] exp);
    total++;
    if (outs() !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, outs(), exp);
    end
  endtask

  // wanted options are active high; pins are driven inverted
  task automatic set_straps(input logic [5:0] want);
    {ag_n, bi_n, mc_n, st_n, hiz_n} = ~want;
  endtask

  task automatic do_reset(input logic [5:0] want, input logic pg);
    @(negedge clk);
    rst_n = 1'b0; pwr_ok = pg; set_straps(want);
    repeat (5) @(negedge clk);
    chk("R2", 7'b0);
    rst_n = 1'b1;
    #0.5 chk("R1", 7'b0);
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    set_straps(6'b111111);
    repeat (3) @(negedge clk);
    chk("R2", 7'b0);
  endtask

  task automatic t_single_options();
    do_reset(6'b000001, 1'b0); chk("R4", 7'b1000001);
    do_reset(6'b000010, 1'b0); chk("R4", 7'b1000010);
    do_reset(6'b000100, 1'b0); chk("R5", 7'b1000100);
    do_reset(6'b001000, 1'b0); chk("R5", 7'b1001000);
    do_reset(6'b000000, 1'b0); chk("R1", 7'b1000000);
  endtask

  task automatic t_agent_ids();
    for (int i = 0; i < 4; i++) begin
      do_reset({i[1:0], 4'b0101}, 1'b1);
      chk("R6", {1'b1, i[1:0], 4'b0101});
    end
  endtask

  task automatic t_hold_after_capture();
    do_reset(6'b101010, 1'b1);
    set_straps(6'b010101);
    repeat (4) @(negedge clk);
    chk("R3", 7'b1101010);
    pwr_ok = 1'b0; @(negedge clk);
    pwr_ok = 1'b1; repeat (2) @(negedge clk);
    chk("R7", 7'b1101010);
  endtask

  task automatic t_warm_vs_cold();
    do_reset(6'b110011, 1'b1); chk("R7", 7'b1110011);
    do_reset(6'b110011, 1'b0); chk("R7", 7'b1110011);
    do_reset(6'b001100, 1'b1); chk("R7", 7'b1001100);
  endtask

  task automatic t_late_change_in_reset();
    @(negedge clk);
    rst_n = 1'b0; set_straps(6'b111111);
    repeat (6) @(negedge clk);
    set_straps(6'b010010);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8", 7'b1010010);
  endtask

  initial begin
    t_reset_state();
    t_single_options();
    t_agent_ids();
    t_hold_after_capture();
    t_warm_vs_cold();
    t_late_change_in_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule